// File: doc/BRIEF.md
# Transmit Frame Descriptor Walker

The walker takes one fixed-size transmit descriptor, handed to it as a single wide word, and turns it into a series of buffer read requests. Together these requests make up one outgoing frame. The descriptor holds a count of active scatter entries and a packed list of entries. Each entry gives a 36-bit buffer address and a 12-bit buffer length. The walker issues one request per non-empty entry, in entry order, over a valid/ready handshake. It adds up the lengths as it goes.

Before each request is issued, the walker checks it against three limits: the entry count, the size of one buffer and the size of the whole frame. When the walk ends, a one-cycle completion pulse carries the result code and the total number of bytes requested. The walker accepts a new descriptor only when it is idle. It does not fetch descriptors from memory and does not move the payload.

Top module: `frame_desc_walker`

## Requirements
- R1: After reset, `desc_ready` is 1, and `req_valid`, `done` and `err_code` are all 0.
- R2: A descriptor is taken in on a clock edge where `desc_valid` and `desc_ready` are both 1. `desc_ready` then stays 0 until the cycle after the `done` pulse.
- R3: The entry count is `desc_data[28:24]` (bits 4:0 of byte 3). A count of 0, or a count above MAX_ENTRIES (20), issues no request. In that case `done` rises in the cycle right after acceptance, with `err_code` = 1 and `frame_len` = 0. Bits 7:5 of byte 3 are ignored.
- R4: Entry i occupies bits [32+48i +: 48] (bytes 4+6i to 9+6i, little-endian). The request address is {entry[35:32], entry[31:0]} and the request length is entry[47:36]. Requests follow ascending entry order.
- R5: An entry whose length is 0 produces no request, and the walk moves on to the next entry.
- R6: While `req_valid` is 1 and `req_ready` is 0, the next cycle still shows `req_valid` = 1 with the same `req_addr` and `req_len`.
- R7: An entry length above MAX_BUF (4092) ends the walk without issuing that request. The result is `err_code` = 2. This check takes priority over R8.
- R8: If the sum of accepted lengths plus the current length would exceed MAX_FRAME (8192), the walk ends without issuing that request, with `err_code` = 3. A total of exactly 8192 is allowed.
- R9: `done` is a one-cycle pulse. It comes in the cycle after the final request is accepted when the last counted entry is non-empty. `frame_len` equals the sum of accepted lengths while `done` is 1, and `err_code` is 0 on success and 0 whenever `done` is 0.
- R10: Entries at positions at or above the count, the three reserved header bytes and the four trailing pad bytes have no effect on the requests or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor word offered |
| desc_ready | output | 1 | Walker idle, descriptor can be taken |
| desc_data | input | DESC_W (1024) | Whole descriptor, byte k at bits [8k+7:8k] |
| req_valid | output | 1 | Buffer read request valid |
| req_ready | input | 1 | Request accepted by the consumer |
| req_addr | output | 36 | Buffer address |
| req_len | output | 12 | Buffer length in bytes |
| done | output | 1 | One-cycle end-of-descriptor pulse |
| err_code | output | 2 | 0 ok, 1 bad count, 2 buffer too long, 3 frame too long |
| frame_len | output | SUM_W (14) | Total accepted bytes, valid with done |

## Verification
The assertions assume that `req_ready` is an ordinary handshake input. They also assume that `desc_data` is only looked at when it is accepted, so the stored copy is the only one that matters during a walk. The bench changes the descriptor inputs only at falling edges and drops `desc_valid` one cycle after presenting it. It drives `req_ready` with random stalls, so the hold rule and the completion timing are both exercised under back-pressure. Random descriptors deliberately include counts outside the legal range, buffer lengths just past 4092, and totals that cross 8192. The random bytes past the count and in the pad areas must all be ignored.

// File: rtl/fdw_pkg.sv
package fdw_pkg;

    localparam int ADDR_W    = 36;
    localparam int LEN_W     = 12;
    localparam int ENT_BITS  = 48;
    localparam int CNT_W     = 5;
    localparam int HDR_BITS  = 32;
    localparam int TAIL_BITS = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } fdw_req_t;

    typedef enum logic [1:0] {
        FDW_OK             = 2'd0,
        FDW_BAD_COUNT      = 2'd1,
        FDW_BUF_TOO_LONG   = 2'd2,
        FDW_FRAME_TOO_LONG = 2'd3
    } fdw_err_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_FIN  = 2'd2
    } fdw_state_e;

    // Packed entry: [31:0] low address, [35:32] high address nibble, [47:36] length
    function automatic fdw_req_t unpack_entry(input logic [ENT_BITS-1:0] raw);
        fdw_req_t r;
        r.addr = {raw[35:32], raw[31:0]};
        r.len  = raw[47:36];
        return r;
    endfunction

    function automatic int desc_bits(input int entries);
        return HDR_BITS + entries * ENT_BITS + TAIL_BITS;
    endfunction

endpackage

// File: rtl/fdw_desc_store.sv
module fdw_desc_store
    import fdw_pkg::*;
#(
    parameter int MAX_ENTRIES = 20,
    localparam int LIST_W = MAX_ENTRIES * ENT_BITS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [CNT_W-1:0]               cnt_in,
    input  logic [LIST_W-1:0]              list_in,
    output logic [CNT_W-1:0]               cnt,
    output fdw_req_t [MAX_ENTRIES-1:0]     ents
);

    logic [LIST_W-1:0] list_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            list_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            list_q <= list_in;
            cnt_q  <= cnt_in;
        end
    end

    assign cnt = cnt_q;

    for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_unpack
        assign ents[g] = unpack_entry(list_q[g*ENT_BITS +: ENT_BITS]);
    end

endmodule

// File: rtl/fdw_entry_pick.sv
module fdw_entry_pick
    import fdw_pkg::*;
#(
    parameter int MAX_ENTRIES = 20
) (
    input  fdw_req_t [MAX_ENTRIES-1:0] ents,
    input  logic [CNT_W-1:0]           idx,
    output fdw_req_t                   ent
);

    always_comb begin
        ent = '0;
        for (int i = 0; i < MAX_ENTRIES; i++) begin
            if (idx == CNT_W'(i)) ent = ents[i];
        end
    end

endmodule

// File: rtl/fdw_len_acc.sv
module fdw_len_acc
    import fdw_pkg::*;
#(
    parameter int MAX_BUF   = 4092,
    parameter int MAX_FRAME = 8192,
    localparam int SUM_W = $clog2(MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             add,
    input  logic [LEN_W-1:0] len,
    output logic [SUM_W-1:0] sum,
    output logic             buf_over,
    output logic             frame_over
);

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W:0]   next_total;

    assign next_total = {1'b0, sum_q} + (SUM_W+1)'(len);
    assign buf_over   = len > LEN_W'(MAX_BUF);
    assign frame_over = next_total > (SUM_W+1)'(MAX_FRAME);
    assign sum        = sum_q;

    always_ff @(posedge clk) begin
        if (rst || clear) sum_q <= '0;
        else if (add)     sum_q <= next_total[SUM_W-1:0];
    end

    // R8: the running total never passes the frame limit
    a_r8_sum_bound: assert property (@(posedge clk) disable iff (rst)
        sum_q <= SUM_W'(MAX_FRAME));

endmodule

// File: rtl/frame_desc_walker.sv
module frame_desc_walker
    import fdw_pkg::*;
#(
    parameter int MAX_ENTRIES = 20,
    parameter int MAX_BUF     = 4092,
    parameter int MAX_FRAME   = 8192,
    localparam int DESC_W = desc_bits(MAX_ENTRIES),
    localparam int SUM_W  = $clog2(MAX_FRAME + 1),
    localparam int LIST_W = MAX_ENTRIES * ENT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [DESC_W-1:0] desc_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [SUM_W-1:0]  frame_len
);

    fdw_state_e state_q, state_d;
    fdw_err_e   code_q, code_d;
    logic [CNT_W-1:0] idx_q, idx_d;

    logic [CNT_W-1:0] cnt_in, cnt;
    logic             cnt_bad_in, accept, is_last;
    logic             acc_clear, acc_add, buf_over, frame_over;
    fdw_req_t [MAX_ENTRIES-1:0] ents;
    fdw_req_t         ent;
    logic [SUM_W-1:0] sum;

    logic unused_hdr_pad;
    assign unused_hdr_pad = ^{desc_data[23:0], desc_data[31:29],
                              desc_data[DESC_W-1 -: TAIL_BITS]};

    assign cnt_in     = desc_data[24 +: CNT_W];
    assign cnt_bad_in = (cnt_in == '0) || (cnt_in > CNT_W'(MAX_ENTRIES));
    assign accept     = desc_valid && desc_ready;

    fdw_desc_store #(.MAX_ENTRIES(MAX_ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .cnt_in  (cnt_in),
        .list_in (desc_data[HDR_BITS +: LIST_W]),
        .cnt     (cnt),
        .ents    (ents)
    );

    fdw_entry_pick #(.MAX_ENTRIES(MAX_ENTRIES)) u_pick (
        .ents (ents),
        .idx  (idx_q),
        .ent  (ent)
    );

    fdw_len_acc #(.MAX_BUF(MAX_BUF), .MAX_FRAME(MAX_FRAME)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .clear      (acc_clear),
        .add        (acc_add),
        .len        (ent.len),
        .sum        (sum),
        .buf_over   (buf_over),
        .frame_over (frame_over)
    );

    assign is_last = (idx_q == cnt - 1'b1);

    always_comb begin
        state_d   = state_q;
        code_d    = code_q;
        idx_d     = idx_q;
        acc_clear = 1'b0;
        acc_add   = 1'b0;
        req_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (desc_valid) begin
                    acc_clear = 1'b1;
                    idx_d     = '0;
                    if (cnt_bad_in) begin
                        state_d = ST_FIN;
                        code_d  = FDW_BAD_COUNT;
                    end else begin
                        state_d = ST_WALK;
                        code_d  = FDW_OK;
                    end
                end
            end
            ST_WALK: begin
                if (ent.len == '0) begin
                    if (is_last) state_d = ST_FIN;
                    else         idx_d   = idx_q + 1'b1;
                end else if (buf_over) begin
                    state_d = ST_FIN;
                    code_d  = FDW_BUF_TOO_LONG;
                end else if (frame_over) begin
                    state_d = ST_FIN;
                    code_d  = FDW_FRAME_TOO_LONG;
                end else begin
                    req_valid = 1'b1;
                    if (req_ready) begin
                        acc_add = 1'b1;
                        if (is_last) state_d = ST_FIN;
                        else         idx_d   = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= FDW_OK;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            idx_q   <= idx_d;
        end
    end

    assign desc_ready = (state_q == ST_IDLE);
    assign done       = (state_q == ST_FIN);
    assign err_code   = done ? code_q : FDW_OK;
    assign frame_len  = sum;
    assign req_addr   = ent.addr;
    assign req_len    = ent.len;

    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

    a_r3_bad_count: assert property (@(posedge clk) disable iff (rst)
        (accept && cnt_bad_in) |=> (done && err_code == FDW_BAD_COUNT && !req_valid));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && is_last) |=> (done && err_code == FDW_OK));

    a_r2_busy: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !desc_ready);

    a_r7_len_limit: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_len <= LEN_W'(MAX_BUF)));

endmodule

// File: tb/tb_frame_desc_walker.sv
module tb_frame_desc_walker;
    localparam int CLK_PERIOD = 10;
    localparam int NENT = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [1023:0] desc_data = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [35:0]   req_addr;
    logic [11:0]   req_len;
    logic          done;
    logic [1:0]    err_code;
    logic [13:0]   frame_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_desc_walker dut (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_data(desc_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .done(done),
        .err_code(err_code), .frame_len(frame_len)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [35:0] t_addr [NENT];
    logic [11:0] t_len  [NENT];
    logic [4:0]  t_cnt;
    bit          rnd_ready;

    logic [35:0] x_addr [NENT];
    logic [11:0] x_len  [NENT];
    int          x_n, x_code, x_sum;
    bit          x_tight;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model();
        x_n = 0; x_sum = 0; x_code = 0; x_tight = 0;
        if (t_cnt == 0 || t_cnt > NENT) begin
            x_code = 1;
            return;
        end
        for (int i = 0; i < int'(t_cnt); i++) begin
            if (t_len[i] == 0) continue;
            if (t_len[i] > 4092) begin x_code = 2; return; end
            if (x_sum + int'(t_len[i]) > 8192) begin x_code = 3; return; end
            x_addr[x_n] = t_addr[i];
            x_len[x_n]  = t_len[i];
            x_n++;
            x_sum += int'(t_len[i]);
        end
        x_tight = (t_len[int'(t_cnt)-1] != 0);
    endfunction

    function automatic logic [11:0] rand_len();
        int r = int'($urandom % 8);
        if (r == 0) return 12'd0;
        if (r == 1) return 12'(4093 + $urandom % 3);
        if (r < 4)  return 12'(3000 + $urandom % 1093);
        return 12'(1 + $urandom % 600);
    endfunction

    task automatic fill_random();
        for (int i = 0; i < NENT; i++) begin
            t_addr[i] = {4'($urandom), 32'($urandom)};
            t_len[i]  = 12'(1 + $urandom % 4000);
        end
    endtask

    task automatic run_desc();
        logic [1023:0] d;
        logic [35:0] s_addr;
        logic [11:0] s_len;
        bit stall = 0, prev_final = 0, busy_ok = 1, fin = 0, r;
        int k = 0, wait_cyc = 0;
        string tag;
        model();
        for (int w = 0; w < 32; w++) d[w*32 +: 32] = $urandom;
        d[24 +: 5] = t_cnt;
        for (int i = 0; i < NENT; i++) d[32 + 48*i +: 48] = {t_len[i], t_addr[i]};
        @(negedge clk);
        check(desc_ready == 1'b1, "R2", "idle before descriptor", desc_ready, 1);
        desc_valid = 1'b1;
        desc_data  = d;
        @(negedge clk);
        desc_valid = 1'b0;
        desc_data  = '0;
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            if (done) begin
                fin = 1;
                tag = (x_code == 1) ? "R3" : (x_code == 2) ? "R7" : (x_code == 3) ? "R8" : "R9";
                check(err_code == 2'(x_code), tag, "result code", err_code, x_code);
                check(frame_len == 14'(x_sum), tag, "frame length", frame_len, x_sum);
                check(k == x_n, "R10", "request count", k, x_n);
                check(busy_ok, "R2", "busy during walk", busy_ok, 1);
                if (x_code == 1) check(cyc == 0, "R3", "done delay", cyc, 0);
                if (x_tight) check(prev_final, "R9", "done after last accept", prev_final, 1);
            end else begin
                wait_cyc = cyc;
                if (desc_ready) busy_ok = 0;
                if (err_code != 0) check(0, "R9", "code without done", err_code, 0);
                if (stall) begin
                    check(req_valid && req_addr == s_addr && req_len == s_len, "R6",
                          "held request", req_addr, s_addr);
                    stall = 0;
                end
                r = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
                req_ready = r;
                prev_final = 0;
                if (req_valid && r) begin
                    if (k < x_n) begin
                        check(req_addr == x_addr[k], "R4", "address", req_addr, x_addr[k]);
                        check(req_len == x_len[k], "R4/R5", "length", req_len, x_len[k]);
                    end else begin
                        check(0, "R10", "extra request", k, x_n);
                    end
                    k++;
                    prev_final = (k == x_n);
                end else if (req_valid) begin
                    stall = 1; s_addr = req_addr; s_len = req_len;
                end
                @(negedge clk);
            end
        end
        if (!fin) check(0, "R9", "no done pulse", wait_cyc, 0);
        req_ready = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "R9", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(desc_ready == 1 && req_valid == 0, "R1", "idle handshake", {desc_ready, req_valid}, 2);
        check(done == 0 && err_code == 0, "R1", "no result", {done, err_code}, 0);

        // simple three-buffer frame, always ready
        rnd_ready = 0;
        fill_random(); t_cnt = 5'd3;
        t_len[0] = 12'd100; t_len[1] = 12'd200; t_len[2] = 12'd300;
        t_addr[0] = 36'hF_0000_0010;
        run_desc();
        // illegal counts: zero, one past max, all ones
        fill_random(); t_cnt = 5'd0;  run_desc();
        fill_random(); t_cnt = 5'd21; run_desc();
        fill_random(); t_cnt = 5'd31; run_desc();
        // full count of small buffers under stalls
        rnd_ready = 1;
        fill_random(); t_cnt = 5'd20;
        for (int i = 0; i < NENT; i++) t_len[i] = 12'(10 + i);
        run_desc();
        // zero entries mixed in, trailing zero, all zero
        fill_random(); t_cnt = 5'd5;
        t_len[1] = 0; t_len[3] = 0; t_len[4] = 0;
        run_desc();
        fill_random(); t_cnt = 5'd4;
        for (int i = 0; i < 4; i++) t_len[i] = 0;
        run_desc();
        // buffer limit: 4092 passes, 4093 stops
        fill_random(); t_cnt = 5'd2; t_len[0] = 12'd4092; t_len[1] = 12'd4;
        run_desc();
        fill_random(); t_cnt = 5'd3; t_len[0] = 12'd50; t_len[1] = 12'd4093;
        run_desc();
        // frame limit: exactly 8192 passes, one more stops
        fill_random(); t_cnt = 5'd3;
        t_len[0] = 12'd4092; t_len[1] = 12'd4092; t_len[2] = 12'd8;
        run_desc();
        fill_random(); t_cnt = 5'd3;
        t_len[0] = 12'd4092; t_len[1] = 12'd4092; t_len[2] = 12'd9;
        run_desc();

        for (int n = 0; n < 300; n++) begin
            fill_random();
            if ($urandom % 10 == 0) t_cnt = ($urandom % 2) ? 5'd0 : 5'(21 + $urandom % 11);
            else                    t_cnt = 5'(1 + $urandom % 20);
            for (int i = 0; i < NENT; i++) if (i < int'(t_cnt)) t_len[i] = rand_len();
            rnd_ready = ($urandom % 4 != 0);
            run_desc();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule